// File: doc/BRIEF.md
# DTO-Driven Horizontal Sample Rate Compressor

This block shrinks a line of 8-bit video samples horizontally by a factor that can be set anywhere from 1 to 2. A phase accumulator moves ahead by one compression step for every output slot. The integer part of the accumulated phase selects which pair of neighbouring input samples brackets the output. The fractional part weights a linear interpolation between that pair. A strobe marks each cycle that carries a new output sample. Because the step is never below 1, at most one output is produced per input, and output never runs ahead of input.

The step is 1 + code/255, taken from an 8-bit code. The accumulator keeps a remainder in units of 1/255. A line event clears the accumulator and loads a new code. The line event is a rising edge on either a write-enable input or a horizontal reference input, as chosen by a select bit. When the oscillator is switched off, every valid input is passed through unchanged, so the factor is 1.

Top module: `hsc_compressor`

## Requirements
- R1: While reset is held and after it, `out_we` is 0 and `out_sample` is 0. The stored step code is 0 (factor 1), and the phase is at zero with no sample history.
- R2: A line event is a rising edge of `wr_en_in` when `rst_src_sel` = 0, or a rising edge of `href_in` when `rst_src_sel` = 1. An edge on the unselected input has no effect on the output stream.
- R3: A line event clears the phase, the remainder and the sample history on the following clock edge. A sample presented in the event cycle is discarded. The next valid sample becomes input 0 of the new line.
- R4: `comp_code` is captured only in a line event cycle. Changing it at any other time has no effect until the next event.
- R5: Output k of a line lies at position P = k·(255+code). Its index is i = P div 255 and its remainder is r = P mod 255. It is emitted, with `out_we` = 1, in the cycle after input sample i+1 is accepted.
- R6: The output value is ((256−r)·x[i] + r·x[i+1] + 128) >> 8, where x[n] is the n-th valid input of the line.
- R7: With code 0, every input from input 1 onward emits the previous input unchanged. With code 255, only inputs 1, 3, 5, … emit, carrying inputs 0, 2, 4, ….
- R8: With `dto_en` = 0, each valid input appears on `out_sample` one cycle later with `out_we` = 1, whatever the code and phase.
- R9: `out_we` is 0 in any cycle that follows a cycle without `in_valid`. While `out_we` is 0, `out_sample` keeps its previous value.
- R10: The phase remainder always stays below 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample valid |
| in_sample | input | 8 | Input video sample |
| comp_code | input | 8 | Compression code, step = 1 + code/255 |
| dto_en | input | 1 | 1 = compress via oscillator, 0 = pass through |
| rst_src_sel | input | 1 | Line event source: 0 = write-enable, 1 = horizontal reference |
| wr_en_in | input | 1 | Write-enable line pulse |
| href_in | input | 1 | Horizontal reference line pulse |
| out_sample | output | 8 | Resampled output sample |
| out_we | output | 1 | Output sample strobe |

## Verification
Every result is due exactly one clock after the input cycle that causes it. An emitted output appears one edge after the bracketing sample i+1 is accepted. A bypassed sample appears one edge after its input. A line event clears the phase at the edge that ends the event cycle. The bench sets up the inputs on a falling edge, waits for one rising edge, and reads the outputs on the next falling edge. Its expectation for that cycle comes from a position model that counts outputs and inputs per line.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

    localparam int DATA_W_DEF = 8;
    localparam int CODE_W_DEF = 8;

    typedef enum logic {
        SRC_WR_EN = 1'b0,
        SRC_HREF  = 1'b1
    } line_src_e;

endpackage

// File: rtl/hsc_line_evt.sv
module hsc_line_evt
    import hsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_sel,
    input  logic wr_en_in,
    input  logic href_in,
    output logic line_evt
);

    typedef struct packed {
        logic wr_en;
        logic href;
    } evt_state_t;

    evt_state_t st_d, st_q;
    logic       wr_rise, href_rise;

    always_comb begin
        st_d.wr_en = wr_en_in;
        st_d.href  = href_in;
        wr_rise    = wr_en_in & ~st_q.wr_en;
        href_rise  = href_in & ~st_q.href;
        line_evt   = (line_src_e'(src_sel) == SRC_HREF) ? href_rise : wr_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // An edge event needs the source to have been low the cycle before
    AST_EVT_IS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        line_evt |-> ((src_sel ? href_in : wr_en_in) && !(src_sel ? st_q.href : st_q.wr_en))); // R2

endmodule

// File: rtl/hsc_dto.sv
module hsc_dto
    import hsc_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              line_evt,
    input  logic [CODE_W-1:0] code_in,
    output logic              emit,
    output logic [CODE_W-1:0] weight
);

    localparam logic [CODE_W:0] DEN = {1'b0, {CODE_W{1'b1}}};

    typedef struct packed {
        logic [CODE_W-1:0] rem;
        logic              gap;
        logic              primed;
        logic [CODE_W-1:0] code;
    } dto_state_t;

    dto_state_t      st_d, st_q;
    logic [CODE_W:0] sum;
    logic [CODE_W:0] wrap;

    always_comb begin
        st_d = st_q;
        emit = 1'b0;
        sum  = {1'b0, st_q.rem} + {1'b0, st_q.code};
        wrap = sum - DEN;
        if (line_evt) begin
            st_d.rem    = '0;
            st_d.gap    = 1'b0;
            st_d.primed = 1'b0;
            st_d.code   = code_in;
        end else if (in_valid) begin
            if (!st_q.primed) begin
                st_d.primed = 1'b1;
            end else if (!st_q.gap) begin
                emit = 1'b1;
                if (sum >= DEN) begin
                    st_d.rem = wrap[CODE_W-1:0];
                    st_d.gap = 1'b1;
                end else begin
                    st_d.rem = sum[CODE_W-1:0];
                    st_d.gap = 1'b0;
                end
            end else begin
                st_d.gap = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign weight = st_q.rem;

    AST_EVT_CLEARS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        line_evt |=> (weight == '0 && !st_q.primed && !st_q.gap)); // R3
    AST_CODE_ONLY_AT_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        !line_evt |=> $stable(st_q.code)); // R4
    AST_REM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, weight} < DEN); // R10
    AST_NO_EMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> in_valid); // R9

endmodule

// File: rtl/hsc_lerp.sv
module hsc_lerp
    import hsc_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int WGT_W  = CODE_W_DEF
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [WGT_W-1:0]  w,
    output logic [DATA_W-1:0] y
);

    localparam int             ACC_W = DATA_W + WGT_W + 1;
    localparam logic [WGT_W:0] ONE_W = {1'b1, {WGT_W{1'b0}}};
    localparam logic [WGT_W:0] HALF  = {2'b01, {(WGT_W-1){1'b0}}};

    logic [WGT_W:0]  w_a;
    logic [ACC_W-1:0] acc;

    always_comb begin
        w_a = ONE_W - {1'b0, w};
        acc = ACC_W'(w_a) * ACC_W'(a) + ACC_W'(w) * ACC_W'(b) + ACC_W'(HALF);
        y   = acc[WGT_W +: DATA_W];
    end

endmodule

// File: rtl/hsc_compressor.sv
module hsc_compressor
    import hsc_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic [CODE_W-1:0] comp_code,
    input  logic              dto_en,
    input  logic              rst_src_sel,
    input  logic              wr_en_in,
    input  logic              href_in,
    output logic [DATA_W-1:0] out_sample,
    output logic              out_we
);

    typedef struct packed {
        logic [DATA_W-1:0] sample;
        logic              we;
        logic [DATA_W-1:0] prev;
    } out_state_t;

    out_state_t        st_d, st_q;
    logic              line_evt;
    logic              emit;
    logic [CODE_W-1:0] weight;
    logic [DATA_W-1:0] lerp_y;

    hsc_line_evt u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (rst_src_sel),
        .wr_en_in (wr_en_in),
        .href_in  (href_in),
        .line_evt (line_evt)
    );

    hsc_dto #(.CODE_W(CODE_W)) u_dto (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .line_evt (line_evt),
        .code_in  (comp_code),
        .emit     (emit),
        .weight   (weight)
    );

    hsc_lerp #(.DATA_W(DATA_W), .WGT_W(CODE_W)) u_lerp (
        .a (st_q.prev),
        .b (in_sample),
        .w (weight),
        .y (lerp_y)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = in_valid ? in_sample : st_q.prev;
        st_d.we   = dto_en ? emit : in_valid;
        if (st_d.we) st_d.sample = dto_en ? lerp_y : in_sample;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_sample = st_q.sample;
    assign out_we     = st_q.we;

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dto_en && in_valid) |=> (out_we && out_sample == $past(in_sample))); // R8
    AST_NO_INPUT_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_we); // R9
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_we |-> $stable(out_sample)); // R9

endmodule

// File: tb/hsc_compressor_test.sv
`timescale 1ns/1ps
module hsc_compressor_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_sample = '0;
    logic [7:0] comp_code = '0;
    logic       dto_en = 1'b0;
    logic       rst_src_sel = 1'b0;
    logic       wr_en_in = 1'b0;
    logic       href_in = 1'b0;
    logic [7:0] out_sample;
    logic       out_we;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int         m_n, m_k, m_cf;
    logic [7:0] hist [0:255];
    logic [7:0] exp_s = '0;

    always #5 clk = ~clk;

    hsc_compressor uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .comp_code(comp_code), .dto_en(dto_en), .rst_src_sel(rst_src_sel),
        .wr_en_in(wr_en_in), .href_in(href_in),
        .out_sample(out_sample), .out_we(out_we)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic model_reset();
        m_n  = 0;
        m_k  = 0;
        m_cf = int'(comp_code);
    endtask

    // one cycle: drive at negedge, check outputs on the following negedge
    task automatic cyc(input bit v, input logic [7:0] d, input bit evt_we,
                       input bit evt_href, input string req);
        bit exp_we = 1'b0;
        bit is_evt;
        int pos, i, r;
        in_valid  = v;
        in_sample = d;
        wr_en_in  = evt_we;
        href_in   = evt_href;
        is_evt = rst_src_sel ? evt_href : evt_we;
        if (is_evt) begin
            model_reset();
        end else if (v) begin
            hist[m_n] = d;
            if (m_n >= 1) begin
                pos = m_k * (255 + m_cf);
                i = pos / 255;
                r = pos % 255;
                if (i == m_n - 1) begin
                    if (dto_en) begin
                        exp_we = 1'b1;
                        exp_s = 8'(((256 - r) * int'(hist[i]) + r * int'(d) + 128) >> 8);
                    end
                    m_k++;
                end
            end
            m_n++;
        end
        if (!dto_en && v) begin
            exp_we = 1'b1;
            exp_s = d;
        end
        @(posedge clk);
        @(negedge clk);
        wr_en_in = 1'b0;
        href_in  = 1'b0;
        chk(out_we == exp_we, {req, " strobe"}, int'(out_we), int'(exp_we));
        chk(out_sample == exp_s, {req, " sample"}, int'(out_sample), int'(exp_s));
    endtask

    task automatic line_start(input logic [7:0] code, input bit use_href, input string req);
        comp_code   = code;
        rst_src_sel = use_href;
        cyc(1'b0, 8'h00, !use_href, use_href, req);
    endtask

    task automatic t_reset();
        chk(out_we == 1'b0, "R1 reset strobe", int'(out_we), 0);
        chk(out_sample == 8'h00, "R1 reset sample", int'(out_sample), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk(out_we == 1'b0, "R1 after release", int'(out_we), 0);
    endtask

    task automatic t_default_factor();
        dto_en = 1'b1;
        comp_code = 8'd200;
        m_cf = 0;
        for (int n = 0; n < 8; n++) cyc(1'b1, 8'(10 + 7 * n), 1'b0, 1'b0, "R1 R7 default factor");
    endtask

    task automatic t_bypass();
        dto_en = 1'b0;
        for (int n = 0; n < 6; n++) cyc(1'b1, 8'(200 - 13 * n), 1'b0, 1'b0, "R8 bypass");
        cyc(1'b0, 8'h55, 1'b0, 1'b0, "R9 bypass idle");
    endtask

    task automatic t_full_compress();
        dto_en = 1'b1;
        line_start(8'd255, 1'b0, "R3 event clears");
        for (int n = 0; n < 10; n++) cyc(1'b1, 8'(3 + 20 * n), 1'b0, 1'b0, "R7 factor two");
    endtask

    task automatic t_midrange();
        dto_en = 1'b1;
        line_start(8'd128, 1'b0, "R3 event");
        for (int n = 0; n < 24; n++) cyc(1'b1, 8'((n * 37) ^ 8'h5A), 1'b0, 1'b0, "R5 R6 interpolate");
        line_start(8'd77, 1'b0, "R3 event");
        for (int n = 0; n < 24; n++) cyc(1'b1, (n % 2 == 1) ? 8'hFF : 8'h00, 1'b0, 1'b0, "R6 R10 extremes");
    endtask

    task automatic t_code_change();
        dto_en = 1'b1;
        line_start(8'd0, 1'b0, "R3 event");
        for (int n = 0; n < 4; n++) cyc(1'b1, 8'(50 + n), 1'b0, 1'b0, "R4 before change");
        comp_code = 8'd255;
        for (int n = 0; n < 6; n++) cyc(1'b1, 8'(90 + 3 * n), 1'b0, 1'b0, "R4 code ignored mid-line");
        cyc(1'b0, 8'h00, 1'b1, 1'b0, "R4 code taken at event");
        for (int n = 0; n < 6; n++) cyc(1'b1, 8'(120 + 5 * n), 1'b0, 1'b0, "R4 new code");
    endtask

    task automatic t_href_select();
        dto_en = 1'b1;
        line_start(8'd100, 1'b1, "R2 href event");
        for (int n = 0; n < 5; n++) cyc(1'b1, 8'(30 * n), 1'b0, 1'b0, "R2 href line");
        cyc(1'b1, 8'd140, 1'b1, 1'b0, "R2 write-enable ignored");
        for (int n = 0; n < 5; n++) cyc(1'b1, 8'(160 + 9 * n), 1'b0, 1'b0, "R2 stream continues");
        cyc(1'b1, 8'd250, 1'b0, 1'b1, "R3 event sample discarded");
        for (int n = 0; n < 5; n++) cyc(1'b1, 8'(70 - 11 * n), 1'b0, 1'b0, "R3 restart at input 0");
    endtask

    task automatic t_gaps();
        dto_en = 1'b1;
        line_start(8'd60, 1'b0, "R3 event");
        for (int n = 0; n < 16; n++) begin
            cyc(1'b1, 8'(17 * n + 4), 1'b0, 1'b0, "R5 gapped stream");
            if (n % 3 == 0) cyc(1'b0, 8'hEE, 1'b0, 1'b0, "R9 gap holds");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_default_factor();
        t_bypass();
        t_full_compress();
        t_midrange();
        t_code_change();
        t_href_select();
        t_gaps();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule